// File: doc/BRIEF.md
# Display Panel Power Sequencer

This block steps an embedded display panel through a fixed power-up and power-down order. It drives panel power, video enable and backlight enable. It raises an aux-ready flag once the panel has booted far enough to accept sideband traffic. A request arrives as a one-cycle panel-on or panel-off strobe. Each stage then holds for a delay counted in millisecond ticks. A free-running prescaler derives those ticks from the input clock.

Each stage delay has two candidate values: a programmed register value and a firmware table value. The larger of the two is used. The boot component of the power-up delay comes from the register side only, and it is added to the selected up value. After power is removed, a lockout stops a new power-on until the power-cycle time has elapsed. A request made during that lockout is remembered and served when the lockout ends.

Top module: `panel_seq`

## Requirements
- R1: While reset is asserted, and after its release with no request, every output is low and `state_code` is 0.
- R2: A panel-on strobe in state 0 raises `pwr_en` alone (state 1). `aux_rdy` and `vid_en` rise together (state 2) after the power-up delay, which equals `dly_boot_reg` plus the selected up value.
- R3: `bl_en` rises (state 3) only after video has been valid for the selected backlight-on delay, and never while `vid_en` is low.
- R4: A panel-off strobe in state 3 drops `bl_en` first (state 4). Video stays valid for the backlight-off delay, then `vid_en` drops (state 5). Power and aux then hold for the power-down delay, after which both drop together.
- R5: After power removal the block sits in lockout (state 6, all enables low) for the power-cycle delay, then returns to state 0.
- R6: Each selected delay is the larger of its register and table inputs. A table value of 0 selects the register value.
- R7: The boot term `dly_boot_reg` has no table counterpart and is always added to the power-up delay.
- R8: With P clock cycles per millisecond and a selected delay of d ms, a timed state lasts between d*P+2 and (d+1)*P+1 cycles, so no stage is ever shorter than its delay.
- R9: A panel-off strobe during state 1 lets the boot delay finish and then goes to state 5, so video and backlight never rise. A panel-off strobe during state 2 lets that delay finish and then goes to state 4, so the backlight never rises.
- R10: A panel-on strobe during states 4, 5 or 6 is latched. When the lockout ends the block goes straight to state 1 instead of state 0.
- R11: State codes: 0 off, 1 booting, 2 video settling, 3 fully on, 4 backlight off, 5 power down, 6 lockout. `busy` is low exactly in states 0 and 3.
- R12: A panel-on strobe in state 3 and a panel-off strobe in state 0 have no effect. When both strobes arrive in the same cycle, off wins: the block stays in state 0, leaves state 3 for state 4, and cancels a latched power-on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| on_req | input | 1 | Panel-on strobe |
| off_req | input | 1 | Panel-off strobe |
| dly_boot_reg | input | 16 | Register boot term of power-up delay, ms |
| dly_up_reg | input | 16 | Register power-up delay, ms |
| dly_up_tbl | input | 16 | Table power-up delay, ms (0 = absent) |
| dly_blon_reg | input | 16 | Register backlight-on delay, ms |
| dly_blon_tbl | input | 16 | Table backlight-on delay, ms |
| dly_bloff_reg | input | 16 | Register backlight-off delay, ms |
| dly_bloff_tbl | input | 16 | Table backlight-off delay, ms |
| dly_down_reg | input | 16 | Register power-down delay, ms |
| dly_down_tbl | input | 16 | Table power-down delay, ms |
| dly_cycle_reg | input | 16 | Register power-cycle delay, ms |
| dly_cycle_tbl | input | 16 | Table power-cycle delay, ms |
| pwr_en | output | 1 | Panel power enable |
| aux_rdy | output | 1 | Panel ready for sideband traffic |
| vid_en | output | 1 | Video enable |
| bl_en | output | 1 | Backlight enable |
| busy | output | 1 | High outside the steady states |
| state_code | output | 3 | Current sequencer state |

## Verification
The panel-on and panel-off strobes can land in the same cycle. The bench provokes this by pulsing both together in three places: the off state, the fully-on state, and the lockout after a power-on has already been latched there. In each case a scoreboard of expected state visits judges the result. It accepts staying off, a backlight-off sequence, and a lockout that ends in state 0 rather than state 1, and it reports any state change it did not expect. Late strobes are also queued during the boot and video stages, and the bench confirms the sequence still finishes the running stage before it turns down.

// File: rtl/pps_pkg.sv
package pps_pkg;
  localparam int NSTG = 5;
  localparam int STG_UP    = 0;
  localparam int STG_BLON  = 1;
  localparam int STG_BLOFF = 2;
  localparam int STG_DOWN  = 3;
  localparam int STG_CYC   = 4;

  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_BOOT  = 3'd1,
    ST_VID   = 3'd2,
    ST_ON    = 3'd3,
    ST_BLOFF = 3'd4,
    ST_DOWN  = 3'd5,
    ST_LOCK  = 3'd6
  } pps_state_e;
endpackage

// File: rtl/pps_tick.sv
module pps_tick #(
  parameter int CLK_HZ  = 100_000_000,
  parameter int TICK_HZ = 1000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int DIV   = (CLK_HZ / TICK_HZ > 1) ? CLK_HZ / TICK_HZ : 2;
  localparam int DIV_W = $clog2(DIV);
  localparam logic [DIV_W-1:0] LAST = DIV_W'(DIV - 1);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             wrap;

  assign wrap = (cnt_q == LAST);

  always_comb begin
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = wrap;
endmodule

// File: rtl/pps_dsel.sv
module pps_dsel #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] reg_val,
  input  logic [DW-1:0] tbl_val,
  output logic [DW-1:0] eff_val
);
  logic tbl_given;
  logic tbl_larger;

  assign tbl_given  = (tbl_val != '0);
  assign tbl_larger = (tbl_val > reg_val);

  always_comb begin
    if (tbl_given && tbl_larger) eff_val = tbl_val;
    else                         eff_val = reg_val;
  end
endmodule

// File: rtl/pps_timer.sv
module pps_timer #(
  parameter int CW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          tick,
  output logic          done
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  // one extra tick guards against a partial first millisecond
  assign cnt_en = load | (tick & (cnt_q != '0));

  always_comb begin
    if (load) cnt_d = load_val + 1'b1;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/pps_ctrl.sv
module pps_ctrl
  import pps_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = DW + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     on_req,
  input  logic                     off_req,
  input  logic [DW-1:0]            boot_dly,
  input  logic [NSTG-1:0][DW-1:0]  eff_dly,
  input  logic                     done,
  output logic                     load,
  output logic [CW-1:0]            load_val,
  output logic                     pwr_en,
  output logic                     aux_rdy,
  output logic                     vid_en,
  output logic                     bl_en,
  output logic                     busy,
  output logic [2:0]               state_code
);
  pps_state_e st_q, st_d;
  logic       pend_off_q, pend_off_d;
  logic       pend_on_q, pend_on_d;
  logic       want_off, want_on, up_phase, down_phase;

  assign up_phase   = (st_q == ST_BOOT) || (st_q == ST_VID);
  assign down_phase = (st_q == ST_BLOFF) || (st_q == ST_DOWN) || (st_q == ST_LOCK);
  assign want_off   = pend_off_q | off_req;
  assign want_on    = (pend_on_q | on_req) & ~off_req;

  always_comb begin
    pend_off_d = 1'b0;
    if (up_phase) begin
      if (off_req)     pend_off_d = 1'b1;
      else if (on_req) pend_off_d = 1'b0;
      else             pend_off_d = pend_off_q;
    end
    pend_on_d = 1'b0;
    if (down_phase) begin
      if (off_req)     pend_on_d = 1'b0;
      else if (on_req) pend_on_d = 1'b1;
      else             pend_on_d = pend_on_q;
    end
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_OFF:   if (on_req && !off_req) st_d = ST_BOOT;
      ST_BOOT:  if (done) st_d = want_off ? ST_DOWN : ST_VID;
      ST_VID:   if (done) st_d = want_off ? ST_BLOFF : ST_ON;
      ST_ON:    if (off_req) st_d = ST_BLOFF;
      ST_BLOFF: if (done) st_d = ST_DOWN;
      ST_DOWN:  if (done) st_d = ST_LOCK;
      ST_LOCK:  if (done) st_d = want_on ? ST_BOOT : ST_OFF;
      default:  st_d = ST_OFF;
    endcase
  end

  always_comb begin
    load_val = '0;
    unique case (st_d)
      ST_BOOT:  load_val = CW'(boot_dly) + CW'(eff_dly[STG_UP]);
      ST_VID:   load_val = CW'(eff_dly[STG_BLON]);
      ST_BLOFF: load_val = CW'(eff_dly[STG_BLOFF]);
      ST_DOWN:  load_val = CW'(eff_dly[STG_DOWN]);
      ST_LOCK:  load_val = CW'(eff_dly[STG_CYC]);
      default:  load_val = '0;
    endcase
  end

  assign load = (st_d != st_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_OFF;
      pend_off_q <= 1'b0;
      pend_on_q  <= 1'b0;
    end else begin
      st_q       <= st_d;
      pend_off_q <= pend_off_d;
      pend_on_q  <= pend_on_d;
    end
  end

  always_comb begin
    pwr_en  = 1'b0;
    aux_rdy = 1'b0;
    vid_en  = 1'b0;
    bl_en   = 1'b0;
    unique case (st_q)
      ST_BOOT:  pwr_en = 1'b1;
      ST_VID:   begin pwr_en = 1'b1; aux_rdy = 1'b1; vid_en = 1'b1; end
      ST_ON:    begin pwr_en = 1'b1; aux_rdy = 1'b1; vid_en = 1'b1; bl_en = 1'b1; end
      ST_BLOFF: begin pwr_en = 1'b1; aux_rdy = 1'b1; vid_en = 1'b1; end
      ST_DOWN:  begin pwr_en = 1'b1; aux_rdy = 1'b1; end
      default:  ;
    endcase
  end

  assign busy       = (st_q != ST_OFF) && (st_q != ST_ON);
  assign state_code = st_q;
endmodule

// File: rtl/panel_seq.sv
module panel_seq
  import pps_pkg::*;
#(
  parameter int CLK_HZ = 100_000_000,
  parameter int DW     = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          on_req,
  input  logic          off_req,
  input  logic [DW-1:0] dly_boot_reg,
  input  logic [DW-1:0] dly_up_reg,
  input  logic [DW-1:0] dly_up_tbl,
  input  logic [DW-1:0] dly_blon_reg,
  input  logic [DW-1:0] dly_blon_tbl,
  input  logic [DW-1:0] dly_bloff_reg,
  input  logic [DW-1:0] dly_bloff_tbl,
  input  logic [DW-1:0] dly_down_reg,
  input  logic [DW-1:0] dly_down_tbl,
  input  logic [DW-1:0] dly_cycle_reg,
  input  logic [DW-1:0] dly_cycle_tbl,
  output logic          pwr_en,
  output logic          aux_rdy,
  output logic          vid_en,
  output logic          bl_en,
  output logic          busy,
  output logic [2:0]    state_code
);
  localparam int CW = DW + 2;

  logic [1:0]              rst_sync_q;
  logic                    rst_int_n;
  logic                    tick, load, done;
  logic [CW-1:0]           load_val;
  logic [NSTG-1:0][DW-1:0] reg_set, tbl_set, eff_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign reg_set[STG_UP]    = dly_up_reg;
  assign reg_set[STG_BLON]  = dly_blon_reg;
  assign reg_set[STG_BLOFF] = dly_bloff_reg;
  assign reg_set[STG_DOWN]  = dly_down_reg;
  assign reg_set[STG_CYC]   = dly_cycle_reg;
  assign tbl_set[STG_UP]    = dly_up_tbl;
  assign tbl_set[STG_BLON]  = dly_blon_tbl;
  assign tbl_set[STG_BLOFF] = dly_bloff_tbl;
  assign tbl_set[STG_DOWN]  = dly_down_tbl;
  assign tbl_set[STG_CYC]   = dly_cycle_tbl;

  for (genvar g = 0; g < NSTG; g++) begin : g_sel
    pps_dsel #(.DW(DW)) u_sel (
      .reg_val (reg_set[g]),
      .tbl_val (tbl_set[g]),
      .eff_val (eff_set[g])
    );
  end

  pps_tick #(.CLK_HZ(CLK_HZ), .TICK_HZ(1000)) u_tick (
    .clk   (clk),
    .rst_n (rst_int_n),
    .tick  (tick)
  );

  pps_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (load),
    .load_val (load_val),
    .tick     (tick),
    .done     (done)
  );

  pps_ctrl #(.DW(DW), .CW(CW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .on_req     (on_req),
    .off_req    (off_req),
    .boot_dly   (dly_boot_reg),
    .eff_dly    (eff_set),
    .done       (done),
    .load       (load),
    .load_val   (load_val),
    .pwr_en     (pwr_en),
    .aux_rdy    (aux_rdy),
    .vid_en     (vid_en),
    .bl_en      (bl_en),
    .busy       (busy),
    .state_code (state_code)
  );
endmodule

// File: rtl/panel_seq_chk.sv
module panel_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       on_req,
  input logic       off_req,
  input logic       pwr_en,
  input logic       aux_rdy,
  input logic       vid_en,
  input logic       bl_en,
  input logic       busy,
  input logic [2:0] state_code
);
  AST_AUX_NEEDS_PWR: assert property (@(posedge clk) disable iff (!rst_n)
    aux_rdy |-> pwr_en); // R2
  AST_VID_NEEDS_AUX: assert property (@(posedge clk) disable iff (!rst_n)
    vid_en |-> aux_rdy); // R2
  AST_BL_NEEDS_VID: assert property (@(posedge clk) disable iff (!rst_n)
    bl_en |-> vid_en); // R3
  AST_BL_AFTER_VID: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bl_en) |-> $past(vid_en)); // R3
  AST_VID_DROP_AFTER_BL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vid_en) |-> !$past(bl_en)); // R4
  AST_PWR_RISE_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_en) |-> ($past(state_code) == 3'd0 || $past(state_code) == 3'd6)); // R5
  AST_IDLE_ONLY_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (state_code == 3'd0 || state_code == 3'd3)); // R11
  AST_ON_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'd3 && !off_req) |=> state_code == 3'd3); // R12
  AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'd0 && !(on_req && !off_req)) |=> state_code == 3'd0); // R12
endmodule

bind panel_seq panel_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .on_req     (on_req),
  .off_req    (off_req),
  .pwr_en     (pwr_en),
  .aux_rdy    (aux_rdy),
  .vid_en     (vid_en),
  .bl_en      (bl_en),
  .busy       (busy),
  .state_code (state_code)
);

// File: tb/test_panel_seq.sv
`timescale 1ns/1ps
module test_panel_seq;
  localparam int P  = 4;
  localparam int DW = 16;

  typedef struct {
    int code;
    int dmin;
    int dmax;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic on_req = 1'b0, off_req = 1'b0;
  logic [DW-1:0] b_reg, u_reg, u_tbl, n_reg, n_tbl, f_reg, f_tbl, d_reg, d_tbl, c_reg, c_tbl;
  logic pwr_en, aux_rdy, vid_en, bl_en, busy;
  logic [2:0] state_code;

  int checks = 0, errors = 0;
  item_t exp_q[$];
  int last_code = 0, dur = 0, win_min = 0, win_max = 0;

  always #5 clk = ~clk;

  panel_seq #(.CLK_HZ(P * 1000), .DW(DW)) i_panel_seq (
    .clk(clk), .rst_n(rst_n), .on_req(on_req), .off_req(off_req),
    .dly_boot_reg(b_reg), .dly_up_reg(u_reg), .dly_up_tbl(u_tbl),
    .dly_blon_reg(n_reg), .dly_blon_tbl(n_tbl),
    .dly_bloff_reg(f_reg), .dly_bloff_tbl(f_tbl),
    .dly_down_reg(d_reg), .dly_down_tbl(d_tbl),
    .dly_cycle_reg(c_reg), .dly_cycle_tbl(c_tbl),
    .pwr_en(pwr_en), .aux_rdy(aux_rdy), .vid_en(vid_en), .bl_en(bl_en),
    .busy(busy), .state_code(state_code));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int sel(input int r, input int t);
    return (t != 0 && t > r) ? t : r; // R6
  endfunction

  // {pwr,aux,vid,bl,busy} per state code, R11
  function automatic logic [4:0] pat(input int code);
    case (code)
      0: return 5'b00000;
      1: return 5'b10001;
      2: return 5'b11101;
      3: return 5'b11110;
      4: return 5'b11101;
      5: return 5'b11001;
      6: return 5'b00001;
      default: return 5'b11111;
    endcase
  endfunction

  task automatic push(input int code, input int d);
    item_t it;
    it.code = code;
    it.dmin = (d < 0) ? 0 : d * P + 2;  // R8 window
    it.dmax = (d < 0) ? 0 : (d + 1) * P + 1;
    exp_q.push_back(it);
  endtask

  function automatic int up_d();  return int'(b_reg) + sel(int'(u_reg), int'(u_tbl)); endfunction // R7
  function automatic int on_d();  return sel(int'(n_reg), int'(n_tbl)); endfunction
  function automatic int bo_d();  return sel(int'(f_reg), int'(f_tbl)); endfunction
  function automatic int dn_d();  return sel(int'(d_reg), int'(d_tbl)); endfunction
  function automatic int cy_d();  return sel(int'(c_reg), int'(c_tbl)); endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (int'(state_code) != last_code) begin
        if (win_max != 0)
          chk(dur >= win_min && dur <= win_max, "R8", $sformatf("stage %0d length", last_code), dur, win_min);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R12", "unexpected state change", int'(state_code), last_code);
          win_max = 0;
        end else begin
          item_t it;
          it = exp_q.pop_front();
          chk(int'(state_code) == it.code, "R9", "state order", int'(state_code), it.code);
          win_min = it.dmin;
          win_max = it.dmax;
        end
        chk({pwr_en, aux_rdy, vid_en, bl_en, busy} == pat(int'(state_code)), "R11",
            "enable pattern", int'({pwr_en, aux_rdy, vid_en, bl_en, busy}), int'(pat(int'(state_code))));
        last_code = int'(state_code);
        dur = 1;
      end else begin
        dur++;
      end
    end
  end

  task automatic pulse(input bit on, input bit off);
    @(negedge clk);
    on_req = on; off_req = off;
    @(negedge clk);
    on_req = 1'b0; off_req = 1'b0;
  endtask

  task automatic wait_code(input int code, input string req);
    int n = 0;
    while (int'(state_code) != code && n < 3000) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
    chk(int'(state_code) == code, req, "reached state", int'(state_code), code);
  endtask

  task automatic drained(input string req);
    chk(exp_q.size() == 0, req, "pending expected states", exp_q.size(), 0);
  endtask

  task automatic full_cycle(input string req);
    push(1, up_d()); push(2, on_d()); push(3, -1);
    pulse(1'b1, 1'b0);
    wait_code(3, req);
    push(4, bo_d()); push(5, dn_d()); push(6, cy_d()); push(0, -1);
    pulse(1'b0, 1'b1);
    wait_code(0, req);
    drained(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    b_reg = 2; u_reg = 3; u_tbl = 5; n_reg = 4; n_tbl = 0;
    f_reg = 2; f_tbl = 3; d_reg = 5; d_tbl = 1; c_reg = 6; c_tbl = 8;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({pwr_en, aux_rdy, vid_en, bl_en, busy} == 5'b0, "R1", "outputs in reset",
        int'({pwr_en, aux_rdy, vid_en, bl_en, busy}), 0);
    chk(state_code == 3'd0, "R1", "code in reset", int'(state_code), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk({pwr_en, aux_rdy, vid_en, bl_en, busy} == 5'b0, "R1", "outputs after reset",
        int'({pwr_en, aux_rdy, vid_en, bl_en, busy}), 0);

    // R2 R3 R4 R5 R6 R7: nominal cycle with mixed sources
    push(1, up_d()); push(2, on_d()); push(3, -1);
    pulse(1'b1, 1'b0);
    wait_code(3, "R2");
    // R12 on while fully on is ignored
    pulse(1'b1, 1'b0);
    repeat (12) @(negedge clk);
    chk(state_code == 3'd3 && bl_en, "R12", "on while on", int'(state_code), 3);
    push(4, bo_d()); push(5, dn_d()); push(6, cy_d()); push(0, -1);
    pulse(1'b0, 1'b1);
    wait_code(0, "R5");
    drained("R4");
    // R12 off while off is ignored; both strobes together stay off
    pulse(1'b0, 1'b1);
    pulse(1'b1, 1'b1);
    repeat (12) @(negedge clk);
    chk(state_code == 3'd0 && !pwr_en, "R12", "off/both while off", int'(state_code), 0);

    // R9 off during boot, then R10 on latched during lockout
    push(1, up_d()); push(5, dn_d()); push(6, cy_d());
    push(1, up_d()); push(2, on_d()); push(3, -1);
    pulse(1'b1, 1'b0);
    repeat (5) @(negedge clk);
    pulse(1'b0, 1'b1);
    wait_code(6, "R9");
    pulse(1'b1, 1'b0);
    wait_code(3, "R10");
    drained("R10");
    // R12 both strobes while on: off wins
    push(4, bo_d()); push(5, dn_d()); push(6, cy_d()); push(0, -1);
    pulse(1'b1, 1'b1);
    wait_code(0, "R12");
    drained("R12");

    // R9 off during video settling: backlight never rises
    push(1, up_d()); push(2, on_d()); push(4, bo_d()); push(5, dn_d()); push(6, cy_d()); push(0, -1);
    pulse(1'b1, 1'b0);
    wait_code(2, "R9");
    pulse(1'b0, 1'b1);
    wait_code(0, "R9");
    drained("R9");

    // R12 latched on cancelled by simultaneous strobes in lockout
    push(1, up_d()); push(2, on_d()); push(3, -1);
    pulse(1'b1, 1'b0);
    wait_code(3, "R12");
    push(4, bo_d()); push(5, dn_d()); push(6, cy_d()); push(0, -1);
    pulse(1'b0, 1'b1);
    wait_code(5, "R10");
    pulse(1'b1, 1'b0);
    wait_code(6, "R12");
    pulse(1'b1, 1'b1);
    wait_code(0, "R12");
    repeat (10) @(negedge clk);
    chk(state_code == 3'd0, "R12", "cancelled power-on", int'(state_code), 0);
    drained("R12");

    // R6 R7 register-only sources with zero tables and zero delays
    b_reg = 3; u_reg = 0; u_tbl = 0; n_reg = 0; n_tbl = 0;
    f_reg = 1; f_tbl = 0; d_reg = 2; d_tbl = 0; c_reg = 4; c_tbl = 0;
    full_cycle("R6");
    // R6 table larger everywhere
    b_reg = 0; u_reg = 1; u_tbl = 6; n_reg = 1; n_tbl = 3;
    f_reg = 0; f_tbl = 2; d_reg = 1; d_tbl = 4; c_reg = 2; c_tbl = 9;
    full_cycle("R7");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule